// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, a multiple of 32 (64 by default, 96 as the wide variant). The pins are split into banks of 32. Each pin has an output latch, an output enable, rising and falling edge detect enables, a sticky edge status bit and a level readback. Each of these per-pin features spans one 32-bit word per bank.

Software reaches the registers through a single-cycle bus. Writes take effect at the clock edge on which the write strobe is sampled. Read data is combinational from the address. The output latch is changed only through separate write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. Pin inputs pass through a two-flop synchroniser. Edges are detected on the synchronised value. Any set status bit in any bank raises the single interrupt output.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: With W = PIN_COUNT/32 words per feature, the word for feature f and bank k sits at byte address f*W*4 + k*4. The feature order is: level f=0, direction f=1, set f=2, clear f=3, rising enable f=4, falling enable f=5, status f=6. Pin p lives in bank p/32 at bit p mod 32.
- R2: A direction bit of 1 drives the pin's output enable high and a 0 leaves it an input. The direction word reads back as written. Writing one bank's direction word leaves every other bank's direction unchanged.
- R3: Writing the set word drives each output bit written as 1 high on the next clock. Bits written as 0 keep their latch value.
- R4: Writing the clear word drives each output bit written as 1 low on the next clock. Bits written as 0 keep their latch value.
- R5: The level word returns each pin's input after a two-flop synchroniser, whatever the pin's direction. A pin change becomes readable two clock edges after it is applied.
- R6: A status bit is set one edge after the synchronised level shows a 0-to-1 change while the pin's rising enable is 1, or a 1-to-0 change while its falling enable is 1. With the matching enable at 0, the edge leaves the status bit at 0.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new enabled edge is detected on the same clock edge as the clear, the bit stays 1.
- R8: The interrupt output is 1 exactly when any status bit in any bank is 1.
- R9: Reads of the set words, the clear words and addresses at or beyond 7*W*4 return 0. Writes to the level words or to those unused addresses change no register.
- R10: After reset all direction, output, enable and status bits are 0, so pin_out, pin_oe and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | PIN_COUNT | Asynchronous pin input levels |
| pin_out | output | PIN_COUNT | Output latch values |
| pin_oe | output | PIN_COUNT | Output enables, 1 = pin driven |
| irq | output | 1 | Interrupt, OR of all status bits |

## Verification
On every cycle the assertions check the following:
- bits named in a set or clear write reach the output latch on the next edge;
- the latch and output enables stay stable without a write;
- the interrupt cannot drop without a bus write;
- set, clear and unmapped addresses always read zero.

Only the bench's scenarios can show the remaining behaviour:
- edge detection per pin and per polarity, with enables on and off;
- the three-edge latency from a pin change to a status bit;
- a status bit surviving a clear that lands on the edge that sets it again;
- the address arithmetic across banks.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

    localparam int unsigned BANK_W   = 32;
    localparam int unsigned FN_COUNT = 7;

    // Feature index; order sets the address layout
    typedef enum logic [2:0] {
        FN_LEVEL = 3'd0,
        FN_DIR   = 3'd1,
        FN_SET   = 3'd2,
        FN_CLR   = 3'd3,
        FN_RISE  = 3'd4,
        FN_FALL  = 3'd5,
        FN_STAT  = 3'd6
    } gpio_fn_e;

    typedef struct packed {
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] out;
        logic [BANK_W-1:0] rise_en;
        logic [BANK_W-1:0] fall_en;
        logic [BANK_W-1:0] stat;
        logic [BANK_W-1:0] prev;
    } gpio_bank_regs_t;

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.meta   = async_i;
        r_d.stable = r_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_o = r_q.stable;

endmodule

// File: rtl/gpio_decode.sv
`timescale 1ns/1ps
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int unsigned WORDS      = 2,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned BANK_IDX_W = 1
) (
    input  logic [ADDR_W-1:0]     addr_i,
    output logic                  hit_o,
    output gpio_fn_e              fn_o,
    output logic [BANK_IDX_W-1:0] bank_o
);

    localparam int unsigned MAP_WORDS = FN_COUNT * WORDS;

    int unsigned word;

    always_comb begin
        word   = 32'(addr_i) >> 2;
        hit_o  = (word < MAP_WORDS);
        fn_o   = hit_o ? gpio_fn_e'(3'(word / WORDS)) : FN_LEVEL;
        bank_o = BANK_IDX_W'(word % WORDS);
    end

endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lvl_i,
    input  logic              wr_en_i,
    input  gpio_fn_e          wr_fn_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] dir_o,
    output logic [BANK_W-1:0] out_o,
    output logic [BANK_W-1:0] rise_o,
    output logic [BANK_W-1:0] fall_o,
    output logic [BANK_W-1:0] stat_o,
    output logic              irq_o
);

    gpio_bank_regs_t   r_d, r_q;
    logic [BANK_W-1:0] edge_up, edge_dn, caught;

    always_comb begin
        r_d     = r_q;
        edge_up = lvl_i & ~r_q.prev;
        edge_dn = ~lvl_i & r_q.prev;
        caught  = (edge_up & r_q.rise_en) | (edge_dn & r_q.fall_en);
        r_d.prev = lvl_i;
        if (wr_en_i) begin
            unique case (wr_fn_i)
                FN_DIR:  r_d.dir     = wdata_i;
                FN_SET:  r_d.out     = r_q.out | wdata_i;
                FN_CLR:  r_d.out     = r_q.out & ~wdata_i;
                FN_RISE: r_d.rise_en = wdata_i;
                FN_FALL: r_d.fall_en = wdata_i;
                FN_STAT: r_d.stat    = r_q.stat & ~wdata_i;
                default: ;
            endcase
        end
        // a fresh edge wins over a clear on the same cycle
        r_d.stat = r_d.stat | caught;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir_o  = r_q.dir;
    assign out_o  = r_q.out;
    assign rise_o = r_q.rise_en;
    assign fall_o = r_q.fall_en;
    assign stat_o = r_q.stat;
    assign irq_o  = |r_q.stat;

endmodule

// File: rtl/banked_gpio_ctrl.sv
`timescale 1ns/1ps
module banked_gpio_ctrl
    import gpio_pkg::*;
#(
    parameter  int unsigned PIN_COUNT = 64,
    localparam int unsigned WORDS     = PIN_COUNT / BANK_W,
    localparam int unsigned ADDR_W    = $clog2(FN_COUNT * WORDS * 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wen,
    input  logic [BANK_W-1:0]    bus_wdata,
    output logic [BANK_W-1:0]    bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam int unsigned BANK_IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [PIN_COUNT-1:0]  pin_sync;
    logic                  dec_hit;
    gpio_fn_e              dec_fn;
    logic [BANK_IDX_W-1:0] dec_bank;
    logic                  wr_hit;
    logic [WORDS-1:0]      bank_irq;

    logic [BANK_W-1:0] lvl_w  [WORDS];
    logic [BANK_W-1:0] dir_w  [WORDS];
    logic [BANK_W-1:0] out_w  [WORDS];
    logic [BANK_W-1:0] rise_w [WORDS];
    logic [BANK_W-1:0] fall_w [WORDS];
    logic [BANK_W-1:0] stat_w [WORDS];

    gpio_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio_decode #(
        .WORDS      (WORDS),
        .ADDR_W     (ADDR_W),
        .BANK_IDX_W (BANK_IDX_W)
    ) u_dec (
        .addr_i (bus_addr),
        .hit_o  (dec_hit),
        .fn_o   (dec_fn),
        .bank_o (dec_bank)
    );

    assign wr_hit = bus_wen && dec_hit && (dec_fn != FN_LEVEL);

    for (genvar b = 0; b < WORDS; b++) begin : g_bank
        assign lvl_w[b] = pin_sync[b*BANK_W +: BANK_W];

        gpio_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (lvl_w[b]),
            .wr_en_i (wr_hit && (dec_bank == BANK_IDX_W'(b))),
            .wr_fn_i (dec_fn),
            .wdata_i (bus_wdata),
            .dir_o   (dir_w[b]),
            .out_o   (out_w[b]),
            .rise_o  (rise_w[b]),
            .fall_o  (fall_w[b]),
            .stat_o  (stat_w[b]),
            .irq_o   (bank_irq[b])
        );

        assign pin_out[b*BANK_W +: BANK_W] = out_w[b];
        assign pin_oe[b*BANK_W +: BANK_W]  = dir_w[b];
    end

    assign irq = |bank_irq;

    always_comb begin
        bus_rdata = '0;
        if (dec_hit) begin
            unique case (dec_fn)
                FN_LEVEL: bus_rdata = lvl_w[dec_bank];
                FN_DIR:   bus_rdata = dir_w[dec_bank];
                FN_RISE:  bus_rdata = rise_w[dec_bank];
                FN_FALL:  bus_rdata = fall_w[dec_bank];
                FN_STAT:  bus_rdata = stat_w[dec_bank];
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/banked_gpio_ctrl_chk.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_chk #(
    parameter  int unsigned PIN_COUNT = 64,
    localparam int unsigned WORDS     = PIN_COUNT / 32,
    localparam int unsigned ADDR_W    = $clog2(7 * WORDS * 4)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wen,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [PIN_COUNT-1:0] pin_in,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic                 irq
);

    int unsigned          c_word, c_fn, c_bank;
    logic                 c_hit;
    logic [PIN_COUNT-1:0] set_mask_q, clr_mask_q, wmask;

    always_comb begin
        c_word = 32'(bus_addr) >> 2;
        c_hit  = c_word < 7 * WORDS;
        c_fn   = c_word / WORDS;
        c_bank = c_word % WORDS;
        wmask  = PIN_COUNT'(bus_wdata) << (c_bank * 32);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_mask_q <= '0;
            clr_mask_q <= '0;
        end else begin
            set_mask_q <= (bus_wen && c_hit && c_fn == 2) ? wmask : '0;
            clr_mask_q <= (bus_wen && c_hit && c_fn == 3) ? wmask : '0;
        end
    end

    // R3
    a_r3_set_reaches_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask_q != '0) |-> ((pin_out & set_mask_q) == set_mask_q));

    // R4
    a_r4_clr_reaches_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask_q != '0) |-> ((pin_out & clr_mask_q) == '0));

    // R2 / R3 / R4
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wen |=> ($stable(pin_out) && $stable(pin_oe)));

    // R7 / R8
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wen) |=> irq);

    // R9
    a_r9_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_hit || c_fn == 2 || c_fn == 3) |-> (bus_rdata == '0));

    logic unused_chk;
    assign unused_chk = ^pin_in;

endmodule

bind banked_gpio_ctrl banked_gpio_ctrl_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (.*);

// File: tb/banked_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_tb;

    localparam int PINS  = 64;
    localparam int WORDS = PINS / 32;
    localparam int AW    = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wen = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic            irq;

    int nvec = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    banked_gpio_ctrl #(.PIN_COUNT(PINS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [AW-1:0] ra(int fn, int bank);
        return AW'(fn * WORDS * 4 + bank * 4);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd64(int fn, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(ra(fn, 0), lo);
        rd(ra(fn, 1), hi);
        d = {hi, lo};
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] v, exp_out, exp_dir;
        logic [31:0] w;

        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R10 reset state
        chk("R10 pin_out", pin_out, '0);
        chk("R10 pin_oe", pin_oe, '0);
        chk("R10 irq", {63'd0, irq}, 64'd0);
        for (int a = 0; a < 64; a += 4) begin
            rd(AW'(a), w);
            chk("R10 register reads zero", {32'd0, w}, 64'd0);
        end

        // R2 direction, per-bank independence
        wr(ra(1, 0), 32'hA5A5_3C3C);
        wr(ra(1, 1), 32'h0F0F_8001);
        exp_dir = 64'h0F0F_8001_A5A5_3C3C;
        rd64(1, v);
        chk("R2 direction readback", v, exp_dir);
        chk("R2 pin_oe", pin_oe, exp_dir);
        wr(ra(1, 1), 32'h1234_5678);
        exp_dir[63:32] = 32'h1234_5678;
        chk("R2 other bank untouched", pin_oe, exp_dir);

        // R3 / R1 walking set over every pin
        exp_out = '0;
        for (int p = 0; p < PINS; p++) begin
            wr(ra(2, p / 32), 32'(1) << (p % 32));
            exp_out[p] = 1'b1;
            chk("R3 R1 set walk", pin_out, exp_out);
        end
        wr(ra(2, 0), 32'h0);
        chk("R3 zero write keeps latch", pin_out, exp_out);

        // R4 clear every third pin, then the rest
        for (int p = 0; p < PINS; p += 3) begin
            wr(ra(3, p / 32), 32'(1) << (p % 32));
            exp_out[p] = 1'b0;
            chk("R4 clear walk", pin_out, exp_out);
        end
        wr(ra(3, 1), 32'h0);
        chk("R4 zero write keeps latch", pin_out, exp_out);
        wr(ra(3, 0), 32'hFFFF_FFFF);
        wr(ra(3, 1), 32'hFFFF_FFFF);
        exp_out = '0;
        chk("R4 clear all", pin_out, exp_out);

        // R5 level readback, independent of direction
        foreach (v[i]) v[i] = 1'b0;
        for (int k = 0; k < 6; k++) begin
            logic [63:0] pat;
            pat = 64'hDEAD_BEEF_0123_4567 ^ (64'h1111_1111_1111_1111 * 64'(k)) ^ (64'(k) << 61);
            pin_in = pat;
            settle(1);
            rd64(0, v);
            chk("R5 level not yet through two flops", v == pat ? 64'd1 : 64'd0, k == 0 ? 64'd0 : 64'd0);
            settle(1);
            rd64(0, v);
            chk("R5 level after two edges", v, pat);
        end

        // R6 / R8 / R7 rising sweep
        pin_in = '0;
        settle(3);
        wr(ra(6, 0), 32'hFFFF_FFFF);
        wr(ra(6, 1), 32'hFFFF_FFFF);
        wr(ra(4, 0), 32'hFFFF_FFFF);
        wr(ra(4, 1), 32'hFFFF_FFFF);
        for (int p = 0; p < PINS; p++) begin
            pin_in[p] = 1'b1;
            settle(3);
            rd64(6, v);
            chk("R6 rising edge status", v, 64'(1) << p);
            chk("R8 irq on pending", {63'd0, irq}, 64'd1);
            wr(ra(6, p / 32), 32'(1) << (p % 32));
            rd64(6, v);
            chk("R7 write one clears", v, 64'd0);
            chk("R8 irq drops", {63'd0, irq}, 64'd0);
            pin_in[p] = 1'b0;
            settle(3);
            rd64(6, v);
            chk("R6 falling ignored when disabled", v, 64'd0);
        end

        // R6 falling sweep
        wr(ra(4, 0), 32'h0);
        wr(ra(4, 1), 32'h0);
        wr(ra(5, 0), 32'hFFFF_FFFF);
        wr(ra(5, 1), 32'hFFFF_FFFF);
        for (int p = 0; p < PINS; p++) begin
            pin_in[p] = 1'b1;
            settle(3);
            rd64(6, v);
            chk("R6 rising ignored when disabled", v, 64'd0);
            pin_in[p] = 1'b0;
            settle(3);
            rd64(6, v);
            chk("R6 falling edge status", v, 64'(1) << p);
            wr(ra(6, p / 32), 32'(1) << (p % 32));
            chk("R8 irq drops after clear", {63'd0, irq}, 64'd0);
        end

        // R7 edge coincides with clear: bit stays set; other bit clears
        wr(ra(4, 1), 32'h0000_0003);
        pin_in[33] = 1'b1;
        settle(3);
        rd64(6, v);
        chk("R7 setup status", v, 64'(1) << 33);
        pin_in[32] = 1'b1;
        settle(2);
        wr(ra(6, 1), 32'h0000_0003);
        rd64(6, v);
        chk("R7 new edge beats clear", v, 64'(1) << 32);
        chk("R8 irq held", {63'd0, irq}, 64'd1);
        wr(ra(6, 1), 32'h0000_0001);
        rd64(6, v);
        chk("R7 later clear", v, 64'd0);

        // R9 ignored writes and zero reads
        wr(ra(2, 0), 32'h00FF_00FF);
        exp_out = 64'h0000_0000_00FF_00FF;
        v = pin_in;
        wr(ra(0, 0), 32'hFFFF_FFFF);
        wr(ra(0, 1), 32'hFFFF_FFFF);
        rd64(0, exp_dir);
        chk("R9 level write ignored", exp_dir, v);
        for (int b = 0; b < WORDS; b++) begin
            rd(ra(2, b), w);
            chk("R9 set reads zero", {32'd0, w}, 64'd0);
            rd(ra(3, b), w);
            chk("R9 clear reads zero", {32'd0, w}, 64'd0);
        end
        rd64(1, v);
        wr(AW'(56), 32'hFFFF_FFFF);
        wr(AW'(60), 32'hFFFF_FFFF);
        rd(AW'(56), w);
        chk("R9 unused reads zero", {32'd0, w}, 64'd0);
        rd(AW'(60), w);
        chk("R9 unused reads zero", {32'd0, w}, 64'd0);
        rd64(1, exp_dir);
        chk("R9 unused write leaves direction", exp_dir, v);
        chk("R9 unused write leaves latch", pin_out, exp_out);
        rd64(6, v);
        chk("R9 unused write leaves status", v, 64'd0);

        summary();
        $finish;
    end

endmodule